// File: doc/BRIEF.md
# Synchronous FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer with a parameterised depth of 2048 or 4096 words. Data moves in and out through a write port and a read port. Both ports are controlled by an active-low enable that is sampled on the rising clock edge. A port-select input, `load_ni`, must be high for any transfer to take place. When it is low, the neighbouring register-access block owns the cycle and the FIFO holds its state. In this block both ports are clocked from one clock.

The block drives five status flags: empty, full, half-full, almost-empty and almost-full. The two "almost" thresholds are held as offset registers inside the block. A mode input chooses which pair of default offsets these registers take at reset. The external register-access block may later overwrite both offsets with a one-cycle strobe.

A retransmit input rewinds the read side to word zero. Reading then replays the stored data from its start.

Top module: `prog_fifo`

## Requirements
- R1: While `rst_ni` is low and after its release, the block shows the reset state: `empty_o`=1, `ae_o`=1, `full_o`=0, `half_o`=0, `af_o`=0 and `rdata_o`=0.
- R2: Words leave in the order they were written. `rdata_o` takes the oldest stored word on the rising edge where a read is accepted, and holds that value until the next accepted read.
- R3: A write is accepted only with `load_ni`=1 and `wen_ni`=0. A read is accepted only with `load_ni`=1 and `ren_ni`=0. With `load_ni`=0, the enables have no effect on the stored data, the flags or `rdata_o`.
- R4: A write while full is dropped and leaves the stored words unchanged. A read while empty is dropped and leaves `rdata_o` unchanged.
- R5: `empty_o` is 1 exactly when no words are stored. `full_o` is 1 exactly when DEPTH words are stored.
- R6: `half_o` is 1 exactly when more than DEPTH/2 words are stored.
- R7: `ae_o` is 1 exactly when the stored count is less than or equal to the almost-empty offset.
- R8: `af_o` is 1 exactly when the free space (DEPTH minus count) is less than or equal to the almost-full offset.
- R9: Reset loads both offsets from `mode_i`. Mode 0 gives 7 for both offsets, and mode 1 gives 63 for both.
- R10: A clock edge with `off_load_i`=1 copies `ae_off_i` into the almost-empty offset and `af_off_i` into the almost-full offset.
- R11: An edge with `retx_ni`=0 sets the read position to word 0. It sets the count to the write position, and it accepts no read and no write in that cycle.
- R12: When a read and a write are both accepted on one edge, the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both ports |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Selects the default offsets loaded at reset |
| load_ni | input | 1 | Port select; must be high for FIFO transfers |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | 18 | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rdata_o | output | 18 | Registered read data |
| retx_ni | input | 1 | Retransmit, active low |
| off_load_i | input | 1 | Strobe that loads both offsets |
| ae_off_i | input | AW | New almost-empty offset |
| af_off_i | input | AW | New almost-full offset |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| half_o | output | 1 | More than DEPTH/2 words stored |
| ae_o | output | 1 | Count at or below the almost-empty offset |
| af_o | output | 1 | Free space at or below the almost-full offset |

## Verification
The assertions take for granted that retransmit is only asked for before the write position has wrapped. Without that, the count recomputed from the write position would not match the stored data. They also take for granted that all inputs are stable at the rising edge. The bench drives every input on the falling edge. It issues retransmit only after a few writes from reset, well short of a wrap, and it asserts load select low only in the cycles that test that the select blocks transfers.

// File: rtl/prog_fifo_pkg.sv
package prog_fifo_pkg;
  localparam int unsigned DATA_W    = 18;
  localparam int unsigned OFF_DEF_0 = 7;
  localparam int unsigned OFF_DEF_1 = 63;

  typedef enum logic {
    MODE_BASIC = 1'b0,
    MODE_EXT   = 1'b1
  } fifo_mode_e;

  function automatic int unsigned def_offset(input fifo_mode_e m);
    return (m == MODE_EXT) ? OFF_DEF_1 : OFF_DEF_0;
  endfunction
endpackage

// File: rtl/prog_fifo_mem.sv
module prog_fifo_mem #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/prog_fifo_ctrl.sv
module prog_fifo_ctrl #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_ni,
  input  logic          wen_ni,
  input  logic          ren_ni,
  input  logic          retx_ni,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          port_ok, retx;

  assign retx    = !retx_ni;
  assign port_ok = load_ni && !retx;
  assign wr_en_o = port_ok && !wen_ni && (cnt_q != CNT_FULL);
  assign rd_en_o = port_ok && !ren_ni && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (retx) begin
      rptr_q <= '0;
      cnt_q  <= {1'b0, wptr_q};
    end else begin
      if (wr_en_o) wptr_q <= wptr_q + 1'b1;
      if (rd_en_o) rptr_q <= rptr_q + 1'b1;
      case ({wr_en_o, rd_en_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/prog_fifo_flags.sv
module prog_fifo_flags
  import prog_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          off_load_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  input  logic [CW-1:0] count_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o,
  output logic          ae_o,
  output logic          af_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  logic [AW-1:0] ae_off_q, af_off_q;
  logic [CW-1:0] space;

  // defaults sampled from mode_i while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= AW'(def_offset(fifo_mode_e'(mode_i)));
      af_off_q <= AW'(def_offset(fifo_mode_e'(mode_i)));
    end else if (off_load_i) begin
      ae_off_q <= ae_off_i;
      af_off_q <= af_off_i;
    end
  end

  assign space   = CNT_FULL - count_i;
  assign empty_o = (count_i == '0);
  assign full_o  = (count_i == CNT_FULL);
  assign half_o  = (count_i > CNT_HALF);
  assign ae_o    = (count_i <= {1'b0, ae_off_q});
  assign af_o    = (space <= {1'b0, af_off_q});
endmodule

// File: rtl/prog_fifo.sv
module prog_fifo
  import prog_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              load_ni,
  input  logic              wen_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_ni,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              retx_ni,
  input  logic              off_load_i,
  input  logic [AW-1:0]     ae_off_i,
  input  logic [AW-1:0]     af_off_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o,
  output logic              ae_o,
  output logic              af_o
);
  logic          wr_en, rd_en;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;

  prog_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .wen_ni  (wen_ni),
    .ren_ni  (ren_ni),
    .retx_ni (retx_ni),
    .wr_en_o (wr_en),
    .rd_en_o (rd_en),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .count_o (count)
  );

  prog_fifo_mem #(.W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .rd_en_i (rd_en),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );

  prog_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .off_load_i (off_load_i),
    .ae_off_i   (ae_off_i),
    .af_off_i   (af_off_i),
    .count_i    (count),
    .empty_o    (empty_o),
    .full_o     (full_o),
    .half_o     (half_o),
    .ae_o       (ae_o),
    .af_o       (af_o)
  );
endmodule

// File: rtl/prog_fifo_chk.sv
module prog_fifo_chk #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_ni,
  input logic          wen_ni,
  input logic          ren_ni,
  input logic          retx_ni,
  input logic [17:0]   rdata_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          half_o,
  input logic          ae_o,
  input logic [CW-1:0] count
);
  a_r5_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !wen_ni && ren_ni && retx_ni) |=> full_o);

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !ren_ni && wen_ni && retx_ni) |=> (empty_o && $stable(rdata_o)));

  a_r3_load_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_ni && retx_ni) |=> ($stable(count) && $stable(rdata_o)));

  a_r12_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retx_ni |=> (count == $past(count) || count == $past(count) + 1'b1
                 || count == $past(count) - 1'b1));

  a_r6_half_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> !empty_o);

  a_r7_empty_is_ae: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> ae_o);
endmodule

bind prog_fifo prog_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_ni (load_ni),
  .wen_ni  (wen_ni),
  .ren_ni  (ren_ni),
  .retx_ni (retx_ni),
  .rdata_o (rdata_o),
  .empty_o (empty_o),
  .full_o  (full_o),
  .half_o  (half_o),
  .ae_o    (ae_o),
  .count   (count)
);

// File: tb/prog_fifo_tb.sv
module prog_fifo_tb;
  localparam int DEPTH = 2048;
  localparam int AW    = $clog2(DEPTH);

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          mode_i = 0;
  logic          load_ni = 1;
  logic          wen_ni = 1;
  logic          ren_ni = 1;
  logic          retx_ni = 1;
  logic          off_load_i = 0;
  logic [AW-1:0] ae_off_i = '0;
  logic [AW-1:0] af_off_i = '0;
  logic [17:0]   wdata_i = '0;
  logic [17:0]   rdata_o;
  logic          empty_o, full_o, half_o, ae_o, af_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  prog_fifo #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk_i);
    rst_ni = 0; mode_i = m;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic push(input int d);
    @(negedge clk_i);
    wen_ni = 0; wdata_i = 18'(d);
    @(negedge clk_i);
    wen_ni = 1;
  endtask

  task automatic pop();
    @(negedge clk_i);
    ren_ni = 0;
    @(negedge clk_i);
    ren_ni = 1;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk_eq("R1 empty in reset", int'(empty_o), 1);
    do_reset(0);
    chk_eq("R1 empty", int'(empty_o), 1);
    chk_eq("R1 ae", int'(ae_o), 1);
    chk_eq("R1 full", int'(full_o), 0);
    chk_eq("R1 half", int'(half_o), 0);
    chk_eq("R1 af", int'(af_o), 0);
    chk_eq("R1 rdata", int'(rdata_o), 0);
  endtask

  task automatic t_order();
    do_reset(0);
    for (int i = 0; i < 5; i++) push(100 + i);
    chk_eq("R5 not empty", int'(empty_o), 0);
    for (int i = 0; i < 5; i++) begin
      pop();
      chk_eq("R2 order", int'(rdata_o), 100 + i);
    end
    chk_eq("R5 empty after drain", int'(empty_o), 1);
    pop();
    chk_eq("R4 read empty holds rdata", int'(rdata_o), 104);
    chk_eq("R4 read empty stays empty", int'(empty_o), 1);
  endtask

  task automatic t_load_sel();
    do_reset(0);
    load_ni = 0;
    push(7);
    chk_eq("R3 write blocked", int'(empty_o), 1);
    load_ni = 1;
    push(55);
    load_ni = 0;
    pop();
    chk_eq("R3 read blocked rdata", int'(rdata_o), 0);
    chk_eq("R3 read blocked empty", int'(empty_o), 0);
    load_ni = 1;
    pop();
    chk_eq("R3 read after select", int'(rdata_o), 55);
  endtask

  task automatic t_mode_defaults();
    do_reset(1);
    for (int i = 0; i < 63; i++) push(i);
    chk_eq("R9 mode1 ae at 63", int'(ae_o), 1);
    push(63);
    chk_eq("R9 mode1 ae clear at 64", int'(ae_o), 0);
    do_reset(0);
    for (int i = 0; i < 7; i++) push(i);
    chk_eq("R9 mode0 ae at 7", int'(ae_o), 1);
    push(7);
    chk_eq("R7 ae clear at 8", int'(ae_o), 0);
  endtask

  task automatic t_fill();
    do_reset(0);
    for (int i = 1; i <= DEPTH; i++) begin
      push(i);
      if (i == DEPTH / 2)   chk_eq("R6 half at D/2", int'(half_o), 0);
      if (i == DEPTH / 2+1) chk_eq("R6 half above D/2", int'(half_o), 1);
      if (i == DEPTH - 8)   chk_eq("R8 af at space 8", int'(af_o), 0);
      if (i == DEPTH - 7)   chk_eq("R8 af at space 7", int'(af_o), 1);
      if (i == DEPTH - 1)   chk_eq("R5 not full", int'(full_o), 0);
    end
    chk_eq("R5 full", int'(full_o), 1);
    push(18'h3ffff);
    chk_eq("R4 write full keeps full", int'(full_o), 1);
    for (int i = 1; i <= DEPTH; i++) begin
      pop();
      if (int'(rdata_o) != i) chk_eq("R4 R2 full data", int'(rdata_o), i);
    end
    chk_eq("R4 dropped write not stored", int'(empty_o), 1);
  endtask

  task automatic t_offset_load();
    do_reset(0);
    @(negedge clk_i);
    off_load_i = 1; ae_off_i = AW'(2); af_off_i = AW'(2040);
    @(negedge clk_i);
    off_load_i = 0;
    push(1); push(2);
    chk_eq("R10 ae at 2", int'(ae_o), 1);
    chk_eq("R10 af space 2046", int'(af_o), 0);
    push(3);
    chk_eq("R10 ae clear at 3", int'(ae_o), 0);
    for (int i = 0; i < 5; i++) push(i);
    chk_eq("R10 af at space 2040", int'(af_o), 1);
  endtask

  task automatic t_retx();
    do_reset(0);
    for (int i = 0; i < 4; i++) push(10 + i);
    pop(); pop();
    chk_eq("R11 pre read", int'(rdata_o), 11);
    @(negedge clk_i);
    retx_ni = 0; ren_ni = 0; wen_ni = 0; wdata_i = 18'd99;
    @(negedge clk_i);
    retx_ni = 1; ren_ni = 1; wen_ni = 1;
    chk_eq("R11 no read on retx edge", int'(rdata_o), 11);
    for (int i = 0; i < 4; i++) begin
      pop();
      chk_eq("R11 replay", int'(rdata_o), 10 + i);
    end
    chk_eq("R11 count from write position", int'(empty_o), 1);
  endtask

  task automatic t_simul();
    do_reset(0);
    push(200);
    @(negedge clk_i);
    wen_ni = 0; ren_ni = 0; wdata_i = 18'd201;
    @(negedge clk_i);
    wen_ni = 1; ren_ni = 1;
    chk_eq("R12 read during write", int'(rdata_o), 200);
    chk_eq("R12 count kept", int'(empty_o), 0);
    pop();
    chk_eq("R12 second word", int'(rdata_o), 201);
    chk_eq("R12 empty after", int'(empty_o), 1);
  endtask

  initial begin
    t_reset();
    t_order();
    t_load_sel();
    t_mode_defaults();
    t_fill();
    t_offset_load();
    t_retx();
    t_simul();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule